// File: doc/BRIEF.md
# Split-width lane RAM with seven narrow read ports

This block is a small distributed memory built from eight storage lanes. Each lane holds 32 words of 2 bits. One shared write port writes all eight lanes at once: a single 5-bit word address, one 2-bit data field per lane, and one write enable. Seven of the lanes each have a private read port that sees the lane as 64 single-bit cells. The upper address bits pick the word and the lowest bit picks the bit inside it. The eighth lane has no private port. It is read at full 2-bit width through the same address that drives writes.

Every read path is combinational. A narrow port follows its address with no clock, and an output shows newly written data as soon as the active write edge has passed. A parameter moves the active edge from rising to falling, for designs that must write on the opposite phase. The block has no reset and no defined initial contents. Its interface is a plain memory interface with no flow control, so a write is never refused or delayed.

Top module: `split_width_ram`

## Requirements
- R1: On each active write edge with `wr_en` high, all eight lanes store their own field of `wr_data` at word `wr_addr`. Lane i uses bits [2i+1:2i], so lanes 0 to 6 are the narrow lanes and lane 7 is the wide lane.
- R2: On an active edge with `wr_en` low, no word of any lane changes, whatever `wr_addr` and `wr_data` carry.
- R3: Narrow port i takes address field `rd_addr[6i+5:6i]`. Its bits [5:1] select a word of lane i and its bit [0] selects the bit of that word (0 for bit 0, 1 for bit 1). The port drives that bit on `rd_bit[i]`.
- R4: Each narrow port returns data only from its own lane. Writing distinct values to different lanes at one word gives distinct values on the matching ports.
- R5: `wide_q` always shows the full 2-bit word of lane 7 at word `wr_addr`.
- R6: Reads are combinational. A change of read address shows on the output with no clock edge, and data written on an active edge is visible right after that edge.
- R7: With `CLK_INV` = 0, writes happen on the rising edge of `wr_clk`. With `CLK_INV` = 1, they happen on the falling edge, and the other edge never writes.
- R8: A write changes only the addressed word. Every other word of every lane keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; the active edge is set by `CLK_INV` |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 5 | Word address for writing all lanes and for reading the wide lane |
| wr_data | input | 16 | Write data, 2 bits per lane, lane i at bits [2i+1:2i] |
| rd_addr | input | 42 | Seven 6-bit narrow read addresses, port i at bits [6i+5:6i] |
| rd_bit | output | 7 | Narrow read data, bit i belongs to port i |
| wide_q | output | 2 | Full word of lane 7 at `wr_addr` |

## Verification
On every active edge, the bound checker confirms four things. A word written on the previous edge reads back on the wide port and on any narrow port aimed at it, with the bit select applied. Nothing moves after an edge with the enable low. A narrow port aimed at some other word keeps its value across a write. Only the bench can show the things a sampled property cannot see. These are the edge choice for each clock polarity, which it shows by placing probes between the two edges. They also include the combinational response to read addresses that change between edges, and the full contents of every lane. The bench reads those contents through exhaustive address sweeps after fills with constant, alternating and random data.

// File: rtl/split_ram_pkg.sv
package split_ram_pkg;

  // Address width needed to index n items; at least one bit so that
  // a select field never collapses to zero width.
  function automatic int unsigned idx_bits(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/wclk_polarity.sv
module wclk_polarity #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk_in,
  output logic clk_act
);

  // The lanes always write on a rising edge of clk_act; the variant
  // chosen here decides which edge of the pin that corresponds to.
  if (INVERT) begin : g_inv
    assign clk_act = ~clk_in;
  end else begin : g_pass
    assign clk_act = clk_in;
  end

endmodule

// File: rtl/ram_lane.sv
module ram_lane #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 2,
  localparam int ADDR_W = split_ram_pkg::idx_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Asynchronous read: no output register.
  assign rdata = cells[raddr];

endmodule

// File: rtl/bit_pick.sv
module bit_pick #(
  parameter int WORD_W = 2,
  localparam int SEL_W = split_ram_pkg::idx_bits(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_o
);

  always_comb begin
    bit_o = word[sel];
  end

endmodule

// File: rtl/split_width_ram.sv
module split_width_ram #(
  parameter int NARROW  = 7,
  parameter int DEPTH   = 32,
  parameter int WORD_W  = 2,
  parameter bit CLK_INV = 1'b0,
  localparam int ADDR_W = split_ram_pkg::idx_bits(DEPTH),
  localparam int SEL_W  = split_ram_pkg::idx_bits(WORD_W),
  localparam int RA_W   = ADDR_W + SEL_W,
  localparam int LANES  = NARROW + 1
) (
  input  logic                      wr_clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*WORD_W-1:0]   wr_data,
  input  logic [NARROW*RA_W-1:0]    rd_addr,
  output logic [NARROW-1:0]         rd_bit,
  output logic [WORD_W-1:0]         wide_q
);

  logic              wclk_act;
  logic [WORD_W-1:0] lane_word [LANES];

  wclk_polarity #(.INVERT(CLK_INV)) u_pol (
    .clk_in (wr_clk),
    .clk_act(wclk_act)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] look;

    if (g < NARROW) begin : g_narrow
      // Upper field picks the word, low field picks the bit.
      assign look = rd_addr[g*RA_W+SEL_W +: ADDR_W];
      bit_pick #(.WORD_W(WORD_W)) u_pick (
        .word (lane_word[g]),
        .sel  (rd_addr[g*RA_W +: SEL_W]),
        .bit_o(rd_bit[g])
      );
    end else begin : g_wide
      // The last lane is read through the write address at full width.
      assign look   = wr_addr;
      assign wide_q = lane_word[g];
    end

    ram_lane #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_lane (
      .clk  (wclk_act),
      .we   (wr_en),
      .waddr(wr_addr),
      .wdata(wr_data[g*WORD_W +: WORD_W]),
      .raddr(look),
      .rdata(lane_word[g])
    );
  end

endmodule

// File: rtl/split_width_ram_chk.sv
module split_width_ram_chk #(
  parameter int NARROW = 7,
  parameter int WORD_W = 2,
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 1,
  localparam int RA_W  = ADDR_W + SEL_W,
  localparam int LANES = NARROW + 1
) (
  input logic                    clk_act,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [LANES*WORD_W-1:0] wr_data,
  input logic [NARROW*RA_W-1:0]  rd_addr,
  input logic [NARROW-1:0]       rd_bit,
  input logic [WORD_W-1:0]       wide_q
);

  // Counts active edges seen; properties using $past wait for two.
  logic [1:0] age = 2'd0;
  always_ff @(posedge clk_act) begin
    if (age != 2'd3) age <= age + 2'd1;
  end

  // R5 / R1: a word written on the last edge reads back on the wide port.
  p_wide_fresh_r5: assert property (@(posedge clk_act) disable iff (age < 2'd2)
    ($past(wr_en) && wr_addr == $past(wr_addr))
      |-> wide_q == $past(wr_data[NARROW*WORD_W +: WORD_W]));

  // R2: with the enable low, outputs hold while addresses hold.
  p_idle_hold_r2: assert property (@(posedge clk_act) disable iff (age < 2'd2)
    (!$past(wr_en) && $stable(rd_addr) && $stable(wr_addr))
      |-> ($stable(rd_bit) && $stable(wide_q)));

  for (genvar g = 0; g < NARROW; g++) begin : g_port
    // R3 / R6: narrow port aimed at the fresh word returns the chosen bit.
    p_narrow_fresh_r3: assert property (@(posedge clk_act) disable iff (age < 2'd2)
      ($past(wr_en) && rd_addr[g*RA_W+SEL_W +: ADDR_W] == $past(wr_addr))
        |-> rd_bit[g] == 1'($past(wr_data[g*WORD_W +: WORD_W]) >> rd_addr[g*RA_W +: SEL_W]));

    // R8: a narrow port aimed elsewhere is untouched by a write.
    p_others_keep_r8: assert property (@(posedge clk_act) disable iff (age < 2'd2)
      ($past(wr_en) && $stable(rd_addr[g*RA_W +: RA_W])
        && rd_addr[g*RA_W+SEL_W +: ADDR_W] != $past(wr_addr))
        |-> $stable(rd_bit[g]));
  end

endmodule

bind split_width_ram split_width_ram_chk #(
  .NARROW(NARROW),
  .WORD_W(WORD_W),
  .ADDR_W(ADDR_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk_act(wclk_act),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rd_addr(rd_addr),
  .rd_bit (rd_bit),
  .wide_q (wide_q)
);

// File: tb/split_width_ram_tb.sv
module split_width_ram_tb;
  localparam int NARROW = 7;
  localparam int DEPTH  = 32;
  localparam int LANES  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        wr_en   = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [41:0] rd_addr = '0;
  logic [6:0]  bit_p, bit_n;
  logic [1:0]  wide_p, wide_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [1:0] mref [LANES][DEPTH];

  split_width_ram #(.CLK_INV(1'b0)) u_dut (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_bit(bit_p), .wide_q(wide_p)
  );

  split_width_ram #(.CLK_INV(1'b1)) u_dut_neg (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_bit(bit_n), .wide_q(wide_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One write, seen by both polarities: inputs settle after a rising edge
  // and hold across the following falling and rising edges.
  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    for (int l = 0; l < LANES; l++) mref[l][a] = d[2*l +: 2];
  endtask

  // Full sweep of every narrow port and the wide port against the model.
  task automatic sweep(input string ctx);
    for (int p = 0; p < NARROW; p++) begin
      for (int a = 0; a < 64; a++) begin
        int e;
        rd_addr[6*p +: 6] = 6'(a);
        #1;
        e = (int'(mref[p][a >> 1]) >> (a & 1)) & 1;
        chk($sformatf("R3 R4 %s port%0d addr%0d rise", ctx, p, a), int'(bit_p[p]), e);
        chk($sformatf("R3 R4 %s port%0d addr%0d fall", ctx, p, a), int'(bit_n[p]), e);
      end
    end
    for (int w = 0; w < DEPTH; w++) begin
      wr_addr = 5'(w);
      #1;
      chk($sformatf("R5 %s word%0d rise", ctx, w), int'(wide_p), int'(mref[7][w]));
      chk($sformatf("R5 %s word%0d fall", ctx, w), int'(wide_n), int'(mref[7][w]));
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);

    // R1: fill with four distinct patterns, sweeping after each.
    for (int pat = 0; pat < 4; pat++) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [15:0] d;
        case (pat)
          0: d = 16'h0000;
          1: d = 16'hFFFF;
          2: d = (a % 2 == 0) ? 16'h5555 : 16'hAAAA;
          default: d = 16'($urandom);
        endcase
        do_write(5'(a), d);
      end
      sweep($sformatf("R1 fill%0d", pat));
    end

    // R4: each lane gets a different word at one address.
    do_write(5'd12, {2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0});
    sweep("R4 distinct");

    // R8: single write, all other words must keep their values.
    do_write(5'd9, ~{mref[7][9], mref[6][9], mref[5][9], mref[4][9],
                     mref[3][9], mref[2][9], mref[1][9], mref[0][9]});
    sweep("R8 single");

    // R2: enable low while address and data wander over many edges.
    for (int c = 0; c < 20; c++) begin
      @(posedge clk); #2;
      wr_addr = 5'($urandom);
      wr_data = 16'($urandom);
    end
    @(posedge clk); #1;
    sweep("R2 idle");

    // R6: narrow output follows an address change without an edge.
    @(posedge clk); #1;
    rd_addr[12 +: 6] = 6'd6;
    #1 chk("R6 async addr a", int'(bit_p[2]), int'(mref[2][3][0]));
    rd_addr[12 +: 6] = 6'd7;
    #1 chk("R6 async addr b", int'(bit_p[2]), int'(mref[2][3][1]));

    // R7 / R6: edge choice per polarity, probing between the edges.
    begin
      logic [1:0] old_w, new_w;
      old_w = mref[7][17];
      new_w = old_w ^ 2'b11;
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = 5'd17; wr_data = {new_w, 14'h1555};
      #1;
      chk("R7 rise dut before edges", int'(wide_p), int'(old_w));
      chk("R7 fall dut before edges", int'(wide_n), int'(old_w));
      #4;
      chk("R7 fall dut after falling edge", int'(wide_n), int'(new_w));
      chk("R7 rise dut after falling edge", int'(wide_p), int'(old_w));
      @(posedge clk); #1;
      chk("R7 R6 rise dut after rising edge", int'(wide_p), int'(new_w));
      wr_en = 1'b0;
      for (int l = 0; l < 7; l++) mref[l][17] = 2'b01;
      mref[7][17] = new_w;
    end

    // Random writes, each followed by random reads on every port.
    for (int it = 0; it < 200; it++) begin
      do_write(5'($urandom), 16'($urandom));
      rd_addr = 42'({$urandom, $urandom});
      wr_addr = 5'($urandom);
      #1;
      for (int p = 0; p < NARROW; p++) begin
        int a, e;
        a = int'(rd_addr[6*p +: 6]);
        e = (int'(mref[p][a >> 1]) >> (a & 1)) & 1;
        chk($sformatf("R3 random port%0d rise", p), int'(bit_p[p]), e);
        chk($sformatf("R3 random port%0d fall", p), int'(bit_n[p]), e);
      end
      chk("R5 random rise", int'(wide_p), int'(mref[7][wr_addr]));
      chk("R5 random fall", int'(wide_n), int'(mref[7][wr_addr]));
    end

    sweep("final");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule